// File: doc/BRIEF.md
# Video Display FIFO DMA Requester

This block sits beside the output FIFOs of a video display path and decides when to ask the DMA engine for another transfer. It watches the free space reported for the luma FIFO and the two chroma FIFOs. When a FIFO has room for another burst, the block raises a one-cycle request for that FIFO. The request threshold is programmable for each field. The chroma FIFOs use half the luma figure, because each chroma plane carries half the samples of luma. Only one request can be outstanding per FIFO at a time. A FIFO cannot be asked for again until the DMA engine reports that its previous transfer has completed.

A single 32-bit configuration word holds two 10-bit thresholds and a 4-bit pacing value, named `incpix` in the ports and requirements. The thresholds are counted in 64-bit doublewords, one for the first field of a frame and one for the second. A write goes into shadow storage and reaches the comparators only at the next field boundary. In raw mode the display path has a single FIFO. The block then requests on the luma channel only, and runs a frame pixel counter paced by `incpix` output clocks.

Top module: `vdisp_dma_req`

## Requirements
- R1: `reg_rdata` returns the last written word with bits 31:26 and 11:10 forced to zero. The field-2 threshold sits in bits 25:16, `incpix` in bits 15:12 and the field-1 threshold in bits 9:0. Reset value is 0.
- R2: Written thresholds reach the comparators only on a cycle with `field_start` high. A write in that same cycle waits for the following boundary.
- R3: `field_sel` low selects the field-1 threshold and high selects the field-2 threshold.
- R4: In BT.656 (`mode`=00) and Y/C (`mode`=01), the luma request fires when `free_y` is at least the selected threshold.
- R5: In those modes a chroma request fires when that FIFO's free count is at least the selected threshold shifted right by one (odd values round down).
- R6: In raw mode (`mode`=10 or 11), chroma requests never fire and luma uses the full threshold. Request bit order is 0 = luma, 1 = Cb, 2 = Cr.
- R7: A request is a pulse one cycle long that appears the cycle after its condition is sampled. After a request fires, no further request is raised for that FIFO until its `dma_done` bit has been sampled high. A `dma_done` bit sampled while nothing is pending has no effect.
- R8: A threshold of 0 raises a request whenever none is pending, whatever the free count.
- R9: In raw mode `pix_count` increases by one after every N cycles with `pix_ce` high, where N is `incpix` and 0 counts as 1. In other modes it holds its value.
- R10: `frame_start` clears `pix_count` and its pacing phase. It takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for the configuration word |
| reg_wdata | input | 32 | Configuration write data |
| reg_rdata | output | 32 | Configuration read-back |
| mode | input | 2 | 00 BT.656, 01 Y/C, 1x raw |
| field_sel | input | 1 | Field being displayed: 0 first, 1 second |
| field_start | input | 1 | Field boundary pulse; loads shadow thresholds |
| frame_start | input | 1 | Frame boundary pulse; clears pixel counter |
| free_y | input | 11 | Free doublewords in luma FIFO |
| free_cb | input | 11 | Free doublewords in Cb FIFO |
| free_cr | input | 11 | Free doublewords in Cr FIFO |
| dma_done | input | 3 | Transfer completion per FIFO (0 luma, 1 Cb, 2 Cr) |
| pix_ce | input | 1 | Output pixel clock enable |
| dma_req | output | 3 | Request pulse per FIFO |
| pix_count | output | 16 | Raw-mode frame pixel counter |

## Verification
The hardest situations to reach are those where several timing rules apply in the same cycle. One is a configuration write landing in the very cycle of a field boundary. Another is a completion arriving while a FIFO is already above threshold, so the next pulse must follow with exactly one cycle of gap. A third is a mode switch into raw while chroma requests are still pending. Random stimulus keeps boundaries, writes and completions frequent and independent, so these coincidences occur often. A cycle-level reference model built from the requirements judges every output. Directed sequences pin down the zero threshold, odd chroma halving, and counter pacing with `incpix` of 0 and 3.

// File: rtl/vdisp_dma_pkg.sv
package vdisp_dma_pkg;

  typedef enum logic [1:0] {
    MODE_BT656   = 2'b00,
    MODE_YC      = 2'b01,
    MODE_RAW     = 2'b10,
    MODE_RAW_ALT = 2'b11
  } vd_mode_e;

  localparam int NCH    = 3;
  localparam int CH_Y   = 0;
  localparam int CH_CB  = 1;
  localparam int CH_CR  = 2;

  // configuration word layout
  localparam int THR_W   = 10;
  localparam int INC_W   = 4;
  localparam int THR1_LO = 0;
  localparam int INC_LO  = 12;
  localparam int THR2_LO = 16;
  localparam logic [31:0] CFG_MASK = 32'h03FF_F3FF;

  function automatic logic is_raw(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic [THR_W-1:0] chroma_thr(input logic [THR_W-1:0] t);
    return t >> 1;
  endfunction

  function automatic logic [INC_W-1:0] pace_len(input logic [INC_W-1:0] n);
    return (n == '0) ? INC_W'(1) : n;
  endfunction

endpackage

// File: rtl/vdr_cfg_regs.sv
module vdr_cfg_regs
  import vdisp_dma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [31:0]      wdata,
  input  logic             field_start,
  output logic [31:0]      rdata,
  output logic [THR_W-1:0] act_thr1,
  output logic [THR_W-1:0] act_thr2,
  output logic [INC_W-1:0] incpix
);
  logic [31:0] shadow_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      act_thr1 <= '0;
      act_thr2 <= '0;
    end else begin
      if (we)
        shadow_q <= wdata & CFG_MASK;
      if (field_start) begin
        act_thr1 <= shadow_q[THR1_LO +: THR_W];
        act_thr2 <= shadow_q[THR2_LO +: THR_W];
      end
    end
  end

  assign rdata  = shadow_q;
  assign incpix = shadow_q[INC_LO +: INC_W];
endmodule

// File: rtl/vdr_chan_req.sv
module vdr_chan_req #(
  parameter int FW = 11,
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [FW-1:0] free_cnt,
  input  logic [TW-1:0] thr,
  input  logic          done,
  output logic          req,
  output logic          pend
);
  localparam int CW = (FW > TW) ? FW : TW;

  logic room_ok;
  logic fire;

  assign room_ok = CW'(free_cnt) >= CW'(thr);
  assign fire    = enable && !pend && room_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req  <= 1'b0;
      pend <= 1'b0;
    end else begin
      req  <= fire;
      pend <= pend ? !done : fire;
    end
  end
endmodule

// File: rtl/vdr_pix_count.sv
module vdr_pix_count
  import vdisp_dma_pkg::*;
#(
  parameter int PCW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             pix_ce,
  input  logic             frame_start,
  input  logic [INC_W-1:0] incpix,
  output logic [PCW-1:0]   pix_count
);
  logic [INC_W-1:0] phase_q;
  logic             wrap;

  assign wrap = (phase_q == pace_len(incpix) - INC_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || frame_start) begin
      phase_q   <= '0;
      pix_count <= '0;
    end else if (count_en && pix_ce) begin
      if (wrap) begin
        phase_q   <= '0;
        pix_count <= pix_count + PCW'(1);
      end else begin
        phase_q   <= phase_q + INC_W'(1);
      end
    end
  end
endmodule

// File: rtl/vdisp_dma_req.sv
module vdisp_dma_req
  import vdisp_dma_pkg::*;
#(
  parameter int FW  = 11,
  parameter int PCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic [1:0]     mode,
  input  logic           field_sel,
  input  logic           field_start,
  input  logic           frame_start,
  input  logic [FW-1:0]  free_y,
  input  logic [FW-1:0]  free_cb,
  input  logic [FW-1:0]  free_cr,
  input  logic [NCH-1:0] dma_done,
  input  logic           pix_ce,
  output logic [NCH-1:0] dma_req,
  output logic [PCW-1:0] pix_count
);
  logic [THR_W-1:0] act_thr1, act_thr2, thr_luma, thr_chroma;
  logic [INC_W-1:0] incpix;
  logic             raw_mode;
  logic [NCH-1:0]   pend;
  logic [FW-1:0]    free_arr [NCH];

  vdr_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata),
    .field_start(field_start), .rdata(reg_rdata),
    .act_thr1(act_thr1), .act_thr2(act_thr2), .incpix(incpix)
  );

  assign raw_mode   = is_raw(mode);
  assign thr_luma   = field_sel ? act_thr2 : act_thr1;
  assign thr_chroma = chroma_thr(thr_luma);

  assign free_arr[CH_Y]  = free_y;
  assign free_arr[CH_CB] = free_cb;
  assign free_arr[CH_CR] = free_cr;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    if (ch == CH_Y) begin : g_luma
      vdr_chan_req #(.FW(FW), .TW(THR_W)) u_req (
        .clk(clk), .rst_n(rst_n), .enable(1'b1), .free_cnt(free_arr[ch]),
        .thr(thr_luma), .done(dma_done[ch]), .req(dma_req[ch]), .pend(pend[ch])
      );
    end else begin : g_chroma
      vdr_chan_req #(.FW(FW), .TW(THR_W)) u_req (
        .clk(clk), .rst_n(rst_n), .enable(!raw_mode), .free_cnt(free_arr[ch]),
        .thr(thr_chroma), .done(dma_done[ch]), .req(dma_req[ch]), .pend(pend[ch])
      );
    end
  end

  vdr_pix_count #(.PCW(PCW)) u_pix (
    .clk(clk), .rst_n(rst_n), .count_en(raw_mode), .pix_ce(pix_ce),
    .frame_start(frame_start), .incpix(incpix), .pix_count(pix_count)
  );
endmodule

// File: rtl/vdisp_dma_req_chk.sv
module vdisp_dma_req_chk #(
  parameter int FW  = 11,
  parameter int PCW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [31:0]    reg_rdata,
  input logic [1:0]     mode,
  input logic           frame_start,
  input logic [FW-1:0]  free_y,
  input logic [9:0]     thr_luma,
  input logic [2:0]     pend,
  input logic [2:0]     dma_req,
  input logic [PCW-1:0] pix_count
);
  // R1: reserved bits read as zero
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[31:26] == 6'd0) && (reg_rdata[11:10] == 2'd0));

  // R4: luma pulse only if room was sufficient at sampling
  p_luma_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req[0] |-> $past({1'b0, free_y} >= {2'b0, thr_luma}));

  // R6: raw mode silences chroma
  p_raw_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |=> (dma_req[2:1] == 2'b00));

  // R7: pulses last one cycle
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|dma_req) |=> ((dma_req & $past(dma_req)) == 3'b000));

  // R7: no request issued from a pending channel
  p_no_dup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|dma_req) |-> ((dma_req & $past(pend)) == 3'b000));

  // R9: counter frozen outside raw mode
  p_hold_nonraw_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[1] && !frame_start) |=> $stable(pix_count));

  // R10: frame start clears counter
  p_frame_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (pix_count == '0));
endmodule

bind vdisp_dma_req vdisp_dma_req_chk #(.FW(FW), .PCW(PCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .mode(mode),
  .frame_start(frame_start), .free_y(free_y), .thr_luma(thr_luma),
  .pend(pend), .dma_req(dma_req), .pix_count(pix_count)
);

// File: tb/vdisp_dma_req_bench.sv
module vdisp_dma_req_bench;
  localparam int FW = 11;
  localparam int PCW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0] mode = 2'b00;
  logic field_sel = 1'b0, field_start = 1'b0, frame_start = 1'b0, pix_ce = 1'b0;
  logic [FW-1:0] free_y = '0, free_cb = '0, free_cr = '0;
  logic [2:0] dma_done = '0;
  logic [2:0] dma_req;
  logic [PCW-1:0] pix_count;

  int n_checks = 0, n_fail = 0;

  // reference state
  logic [31:0] m_sh;
  logic [9:0] m_a1, m_a2;
  logic [2:0] m_pend, m_req;
  logic [3:0] m_ph;
  logic [PCW-1:0] m_pix;

  always #10 clk = ~clk;

  vdisp_dma_req #(.FW(FW), .PCW(PCW)) u_vdisp_dma_req (.*);

  function automatic logic [9:0] f_thr(input logic fs, input logic [9:0] a1, input logic [9:0] a2);
    return fs ? a2 : a1;
  endfunction

  function automatic logic f_room(input logic [FW-1:0] fr, input logic [9:0] t);
    return int'(fr) >= int'(t);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic [9:0] t;
    logic [2:0] fire;
    logic [3:0] n;
    t = f_thr(field_sel, m_a1, m_a2);
    fire[0] = !m_pend[0] && f_room(free_y, t);
    fire[1] = !mode[1] && !m_pend[1] && f_room(free_cb, t / 2);
    fire[2] = !mode[1] && !m_pend[2] && f_room(free_cr, t / 2);
    for (int i = 0; i < 3; i++)
      m_pend[i] = m_pend[i] ? !dma_done[i] : fire[i];
    m_req = fire;
    n = (m_sh[15:12] == 0) ? 4'd1 : m_sh[15:12];
    if (frame_start) begin m_ph = 0; m_pix = 0; end
    else if (mode[1] && pix_ce) begin
      if (m_ph + 1 == n) begin m_ph = 0; m_pix = m_pix + 1; end
      else m_ph = m_ph + 1;
    end
    if (field_start) begin m_a1 = m_sh[9:0]; m_a2 = m_sh[25:16]; end
    if (reg_we) m_sh = reg_wdata & 32'h03FF_F3FF;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #2;
    check("R1 rdata", reg_rdata, m_sh);
    check(mode[1] ? "R6 luma req" : "R4 luma req", 32'(dma_req[0]), 32'(m_req[0]));
    check(mode[1] ? "R6 chroma req" : "R5 chroma req", 32'(dma_req[2:1]), 32'(m_req[2:1]));
    check("R9 pix_count", 32'(pix_count), 32'(m_pix));
  endtask

  task automatic idle();
    reg_we = 0; field_start = 0; frame_start = 0; dma_done = 0; pix_ce = 0;
  endtask

  initial begin
    #3000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    m_sh = 0; m_a1 = 0; m_a2 = 0; m_pend = 0; m_req = 0; m_ph = 0; m_pix = 0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset rdata", reg_rdata, 0);
    check("R7 reset req", 32'(dma_req), 0);
    check("R10 reset pix", 32'(pix_count), 0);
    rst_n = 1;

    // R8: zero threshold fires with empty FIFOs
    step();
    check("R8 zero threshold", 32'(dma_req), 32'h7);
    step();
    check("R7 pulse ends", 32'(dma_req), 0);
    step();
    check("R7 held while pending", 32'(dma_req), 0);

    // R1: reserved bits drop
    reg_we = 1; reg_wdata = 32'hFFFF_FFFF;
    step(); idle();
    check("R1 masked word", reg_rdata, 32'h03FF_F3FF);

    // R2/R3/R5: field-1 threshold 7, field-2 threshold 40
    reg_we = 1; reg_wdata = (32'd40 << 16) | 32'd7;
    step(); idle();
    field_start = 1; step(); idle();
    free_y = 6; free_cb = 3; free_cr = 2; field_sel = 0;
    dma_done = 3'b111; step(); idle();
    step();
    check("R5 odd half threshold", 32'(dma_req), 32'h2);
    dma_done = 3'b111; step(); idle();
    field_sel = 1; free_y = 40; free_cb = 19; free_cr = 20;
    step();
    check("R3 field-2 threshold", 32'(dma_req), 32'h5);

    // R9/R10: raw pacing with incpix 3 then 0
    mode = 2'b10; dma_done = 3'b111;
    reg_we = 1; reg_wdata = 32'h0000_3000; frame_start = 1; pix_ce = 1;
    step(); reg_we = 0; frame_start = 0;
    check("R10 cleared", 32'(pix_count), 0);
    repeat (9) step();
    check("R9 incpix 3", 32'(pix_count), 3);
    reg_we = 1; reg_wdata = 32'h0; frame_start = 1;
    step(); reg_we = 0; frame_start = 0;
    repeat (5) step();
    check("R9 incpix 0 as 1", 32'(pix_count), 5);
    mode = 2'b01;
    repeat (4) step();
    check("R9 held outside raw", 32'(pix_count), 5);
    idle();

    // random phase
    for (int c = 0; c < 6000; c++) begin
      reg_we      = ($urandom_range(0, 19) == 0);
      reg_wdata   = $urandom();
      field_start = ($urandom_range(0, 15) == 0);
      frame_start = ($urandom_range(0, 40) == 0);
      if ($urandom_range(0, 63) == 0) mode = 2'($urandom());
      if ($urandom_range(0, 7) == 0) field_sel = ~field_sel;
      free_y   = FW'($urandom_range(0, 1100));
      free_cb  = FW'($urandom_range(0, 600));
      free_cr  = FW'($urandom_range(0, 600));
      dma_done = 3'($urandom());
      pix_ce   = $urandom_range(0, 1) == 1;
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule